// File: doc/BRIEF.md
# Sleep and wake power sequencer

This block is the power-management state machine of a processor. On a sleep request it first pulls the system reset low. After a fixed delay it drops the regulator enable and parks in a sleep state. While asleep it watches sixteen GPIO wake lines, each gated by its own enable bit. A line counts as a wake event only after it has stayed high for a minimum number of reference-clock cycles. Shorter pulses are treated as glitches.

A valid wake event starts a fixed bring-up order. The regulator is re-enabled after a bounded delay. The sequencer then waits for the supply-fault indication to clear, which stands in for the core supply becoming stable. Reset is released after a delay picked by two configuration bits, and the boot chip-select is asserted a short time after that. A low battery-fault input keeps the block asleep. A supply fault during bring-up sends it back to sleep with the regulator off. All delays are parameters counted in the reference clock.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, the block is asleep: reg_en_o = 0, rst_no = 0, boot_cs_no = 1.
- R2: In sleep, a GPIO line whose bit in wake_mask_i is 1 is a valid wake event once it has been sampled high on ASSERT_CYC consecutive clock edges. A pulse seen on fewer edges does not wake the block.
- R3: A GPIO line whose bit in wake_mask_i is 0 never wakes the block, however long it stays high.
- R4: reg_en_o rises exactly ASSERT_CYC + 1 + PWRUP_CYC clock edges after the edge that first samples a valid wake line high.
- R5: When vdd_fault_ni is high, rst_no rises 1 + D edges after reg_en_o rises. D is RST_FAST_CYC if cfg_fwake_i = 1 (this wins over cfg_pde_i), RST_PDE_CYC if only cfg_pde_i = 1, and RST_NORM_CYC if both are 0.
- R6: The configuration bits are sampled only on the edge that leaves sleep. Changing them later in the same wake-up has no effect on its timing.
- R7: boot_cs_no falls exactly CS_CYC edges after rst_no rises, and it is never low while rst_no is low.
- R8: A sleep_req_i high at an edge while awake pulls rst_no low after that edge. reg_en_o falls ENTER_CYC edges later. rst_no is low at every fall of reg_en_o that is not caused by a supply fault.
- R9: While batt_fault_ni is low, the block stays asleep and wake lines are ignored.
- R10: If vdd_fault_ni is low at an edge during reset release or boot, the block returns to sleep on that edge, with reg_en_o = 0 and rst_no = 0.
- R11: If vdd_fault_ni is still low after VCC_MAX_CYC edges with the regulator on, the block returns to sleep. reg_en_o is then high for exactly VCC_MAX_CYC cycles and rst_no never rises.
- R12: sleep_req_i is ignored during wake-up. It has no effect on the wake-up timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_gpio_i | input | 16 | GPIO wake sources, active high |
| wake_mask_i | input | 16 | Per-line wake enable |
| batt_fault_ni | input | 1 | Battery fault, active low |
| vdd_fault_ni | input | 1 | Supply fault, active low (high = supply stable) |
| cfg_pde_i | input | 1 | Power-down-enable profile select |
| cfg_fwake_i | input | 1 | Fast-wake profile select |
| reg_en_o | output | 1 | Regulator enable |
| rst_no | output | 1 | System reset, active low |
| boot_cs_no | output | 1 | Boot chip-select, active low |

## Verification
The bench sweeps every wake line against all four configuration pairs and counts edges at each stage of bring-up against sums of the delay parameters. An off-by-one in any counter, or a profile priority that lets power-down-enable override fast-wake, shows up as a wrong count. It flips the configuration bits mid-wake and pulses a sleep request during bring-up. A design that resamples or obeys these would change the reset delay. Pulses one edge short of and exactly at the hold time separate a glitch filter that is too loose from one that is too strict. Masked lines, a battery fault, a supply fault during reset release, and a supply that never settles check that the block stays asleep or returns to sleep rather than running on.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTER,
    ST_SLEEP,
    ST_PWRON,
    ST_WAITV,
    ST_RELRST,
    ST_BOOT
  } seq_state_e;

  typedef enum logic [1:0] {
    PROF_NORM,
    PROF_PDE,
    PROF_FAST
  } rst_prof_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_wake_qual.sv
module pwrseq_wake_qual #(
  parameter int unsigned NUM  = 16,
  parameter int unsigned HOLD = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic [NUM-1:0] src_i,
  input  logic [NUM-1:0] mask_i,
  output logic           wake_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [NUM-1:0] hit;

  for (genvar g = 0; g < NUM; g++) begin : g_line
    logic [HW-1:0] cnt_q;
    logic          live;

    assign live = arm_i & src_i[g] & mask_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (!live)                cnt_q <= '0;
      else if (cnt_q != HW'(HOLD))   cnt_q <= cnt_q + 1'b1;
    end

    assign hit[g] = (cnt_q == HW'(HOLD));

    AST_HIT_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[g] |-> $past(src_i[g] && mask_i[g] && arm_i)); // R2
  end

  assign wake_o = |hit;

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R4

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned W            = 10,
  parameter int unsigned ENTER_CYC    = 1,
  parameter int unsigned PWRUP_CYC    = 3,
  parameter int unsigned VCC_MAX_CYC  = 328,
  parameter int unsigned RST_PDE_CYC  = 918,
  parameter int unsigned RST_FAST_CYC = 21,
  parameter int unsigned RST_NORM_CYC = 344,
  parameter int unsigned CS_CYC       = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_req_i,
  input  logic         wake_i,
  input  logic         batt_fault_ni,
  input  logic         vdd_fault_ni,
  input  logic         cfg_pde_i,
  input  logic         cfg_fwake_i,
  input  logic         tmr_done_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         arm_o,
  output logic         reg_en_o,
  output logic         rst_no,
  output logic         boot_cs_no
);
  seq_state_e state_q, state_d;
  rst_prof_e  prof_q, prof_d;
  logic [W-1:0] rst_dly;

  always_comb begin
    unique case (prof_q)
      PROF_FAST: rst_dly = W'(RST_FAST_CYC - 1);
      PROF_PDE:  rst_dly = W'(RST_PDE_CYC - 1);
      default:   rst_dly = W'(RST_NORM_CYC - 1);
    endcase
  end

  always_comb begin
    state_d    = state_q;
    prof_d     = prof_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_ACTIVE: if (sleep_req_i) begin
        state_d    = ST_ENTER;
        tmr_load_o = 1'b1;
        tmr_val_o  = W'(ENTER_CYC - 1);
      end
      ST_ENTER: if (tmr_done_i) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_i && batt_fault_ni) begin
        state_d    = ST_PWRON;
        tmr_load_o = 1'b1;
        tmr_val_o  = W'(PWRUP_CYC - 1);
        // fast wake wins when both bits are set
        if (cfg_fwake_i)    prof_d = PROF_FAST;
        else if (cfg_pde_i) prof_d = PROF_PDE;
        else                prof_d = PROF_NORM;
      end
      ST_PWRON: if (tmr_done_i) begin
        state_d    = ST_WAITV;
        tmr_load_o = 1'b1;
        tmr_val_o  = W'(VCC_MAX_CYC - 1);
      end
      ST_WAITV: begin
        if (vdd_fault_ni) begin
          state_d    = ST_RELRST;
          tmr_load_o = 1'b1;
          tmr_val_o  = rst_dly;
        end else if (tmr_done_i) begin
          state_d = ST_SLEEP;
        end
      end
      ST_RELRST: begin
        if (!vdd_fault_ni) state_d = ST_SLEEP;
        else if (tmr_done_i) begin
          state_d    = ST_BOOT;
          tmr_load_o = 1'b1;
          tmr_val_o  = W'(CS_CYC - 1);
        end
      end
      ST_BOOT: begin
        if (!vdd_fault_ni)   state_d = ST_SLEEP;
        else if (tmr_done_i) state_d = ST_ACTIVE;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      prof_q  <= PROF_NORM;
    end else begin
      state_q <= state_d;
      prof_q  <= prof_d;
    end
  end

  assign arm_o      = (state_q == ST_SLEEP);
  assign reg_en_o   = (state_q == ST_ACTIVE) || (state_q == ST_ENTER) ||
                      (state_q == ST_WAITV)  || (state_q == ST_RELRST) ||
                      (state_q == ST_BOOT);
  assign rst_no     = (state_q == ST_ACTIVE) || (state_q == ST_BOOT);
  assign boot_cs_no = (state_q != ST_ACTIVE);

  AST_BATT_BLOCKS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !batt_fault_ni) |=> state_q == ST_SLEEP); // R9
  AST_PROF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SLEEP && $past(state_q != ST_SLEEP)) |-> $stable(prof_q)); // R6
  AST_VDD_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RELRST || state_q == ST_BOOT) && !vdd_fault_ni)
      |=> state_q == ST_SLEEP); // R10
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELRST && vdd_fault_ni && !tmr_done_i)
      |=> state_q == ST_RELRST); // R12

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned NUM_WAKE     = 16,
  parameter int unsigned ASSERT_CYC   = 3,
  parameter int unsigned ENTER_CYC    = 1,
  parameter int unsigned PWRUP_CYC    = 3,
  parameter int unsigned VCC_MAX_CYC  = 328,
  parameter int unsigned RST_PDE_CYC  = 918,
  parameter int unsigned RST_FAST_CYC = 21,
  parameter int unsigned RST_NORM_CYC = 344,
  parameter int unsigned CS_CYC       = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic [NUM_WAKE-1:0] wake_gpio_i,
  input  logic [NUM_WAKE-1:0] wake_mask_i,
  input  logic                batt_fault_ni,
  input  logic                vdd_fault_ni,
  input  logic                cfg_pde_i,
  input  logic                cfg_fwake_i,
  output logic                reg_en_o,
  output logic                rst_no,
  output logic                boot_cs_no
);
  localparam int unsigned MAX_A   = max2(max2(ENTER_CYC, PWRUP_CYC), max2(VCC_MAX_CYC, CS_CYC));
  localparam int unsigned MAX_B   = max2(max2(RST_PDE_CYC, RST_FAST_CYC), RST_NORM_CYC);
  localparam int unsigned MAX_CYC = max2(MAX_A, MAX_B);
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  logic          wake, arm, tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  pwrseq_wake_qual #(.NUM(NUM_WAKE), .HOLD(ASSERT_CYC)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .src_i  (wake_gpio_i),
    .mask_i (wake_mask_i),
    .wake_o (wake)
  );

  pwrseq_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  pwrseq_fsm #(
    .W(TW), .ENTER_CYC(ENTER_CYC), .PWRUP_CYC(PWRUP_CYC),
    .VCC_MAX_CYC(VCC_MAX_CYC), .RST_PDE_CYC(RST_PDE_CYC),
    .RST_FAST_CYC(RST_FAST_CYC), .RST_NORM_CYC(RST_NORM_CYC), .CS_CYC(CS_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .wake_i       (wake),
    .batt_fault_ni(batt_fault_ni),
    .vdd_fault_ni (vdd_fault_ni),
    .cfg_pde_i    (cfg_pde_i),
    .cfg_fwake_i  (cfg_fwake_i),
    .tmr_done_i   (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .arm_o        (arm),
    .reg_en_o     (reg_en_o),
    .rst_no       (rst_no),
    .boot_cs_no   (boot_cs_no)
  );

  AST_CS_UNDER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_cs_no |-> rst_no); // R7
  AST_RST_NEEDS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no |-> reg_en_o); // R8
  AST_RST_BEFORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(reg_en_o) && $past(vdd_fault_ni)) |-> $past(!rst_no)); // R8
  AST_REG_NEEDS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> $past(batt_fault_ni, 1) || $past(!arm)); // R9

endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int T_A = 3, T_ENT = 2, T_PWR = 3, T_VCC = 20;
  localparam int T_PDE = 12, T_FAST = 5, T_NORM = 8, T_CS = 2;

  logic clk = 0, rst_ni = 0, sleep_req = 0, batt_n = 1, vdd_n = 1, pde = 0, fw = 0;
  logic [15:0] gpio = '0, mask = '1;
  logic reg_en, rst_n_o, cs_n;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(
    .ASSERT_CYC(T_A), .ENTER_CYC(T_ENT), .PWRUP_CYC(T_PWR), .VCC_MAX_CYC(T_VCC),
    .RST_PDE_CYC(T_PDE), .RST_FAST_CYC(T_FAST), .RST_NORM_CYC(T_NORM), .CS_CYC(T_CS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .wake_gpio_i(gpio),
    .wake_mask_i(mask), .batt_fault_ni(batt_n), .vdd_fault_ni(vdd_n),
    .cfg_pde_i(pde), .cfg_fwake_i(fw), .reg_en_o(reg_en), .rst_no(rst_n_o),
    .boot_cs_no(cs_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // sel: 0 reg_en, 1 rst_no, 2 boot_cs_no
  task automatic edges_until(input int sel, input logic val, output int n);
    logic s;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      tick();
      n++;
      s = (sel == 0) ? reg_en : (sel == 1) ? rst_n_o : cs_n;
      if (s == val) return;
    end
    n = -1;
  endtask

  task automatic stay_asleep(input int cyc, input string req);
    int hi = 0;
    for (int k = 0; k < cyc; k++) begin
      tick();
      if (reg_en) hi++;
    end
    chk(hi == 0, req, hi, 0);
  endtask

  task automatic go_sleep();
    int n;
    sleep_req = 1;
    tick();
    sleep_req = 0;
    chk(!rst_n_o && reg_en, "R8 reset first", int'(rst_n_o), 0);
    edges_until(0, 1'b0, n);
    chk(n + 1 == 1 + T_ENT, "R8 regulator off delay", n + 1, 1 + T_ENT);
  endtask

  task automatic wake_run(input int b, input bit p, input bit f);
    int n, exp_r;
    pde = p; fw = f;
    exp_r = f ? T_FAST : (p ? T_PDE : T_NORM);
    gpio[b] = 1'b1;
    edges_until(0, 1'b1, n);
    chk(n == T_A + 1 + T_PWR, "R4 regulator on delay", n, T_A + 1 + T_PWR);
    gpio[b] = 1'b0;
    pde = ~p; fw = ~f;   // R6 late change must not matter
    sleep_req = 1;       // R12 ignored while waking
    tick();
    sleep_req = 0;
    if (rst_n_o) n = 1; else begin edges_until(1, 1'b1, n); n++; end
    chk(n == 1 + exp_r, "R5 R6 R12 reset release delay", n, 1 + exp_r);
    chk(cs_n == 1'b1, "R7 cs high at reset release", int'(cs_n), 1);
    edges_until(2, 1'b0, n);
    chk(n == T_CS, "R7 chip-select delay", n, T_CS);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    chk(!reg_en && !rst_n_o && cs_n, "R1 state in reset", {reg_en, rst_n_o, cs_n}, 3'b001);
    rst_ni = 1;
    tick();
    chk(!reg_en && !rst_n_o && cs_n, "R1 state after reset", {reg_en, rst_n_o, cs_n}, 3'b001);

    // sweep every line and every profile
    for (int b = 0; b < 16; b++)
      for (int c = 0; c < 4; c++) begin
        wake_run(b, c[0], c[1]);
        go_sleep();
      end

    // R2 glitch one edge short
    gpio[7] = 1'b1;
    repeat (T_A - 1) tick();
    gpio[7] = 1'b0;
    stay_asleep(15, "R2 short pulse ignored");
    // R2 exactly the hold time
    gpio[7] = 1'b1;
    repeat (T_A) tick();
    gpio[7] = 1'b0;
    edges_until(0, 1'b1, n);
    chk(n == 1 + T_PWR, "R2 exact hold wakes", n, 1 + T_PWR);
    edges_until(2, 1'b0, n);
    go_sleep();

    // R3 masked line
    mask = 16'hFFFF & ~16'h0020;
    gpio[5] = 1'b1;
    stay_asleep(20, "R3 masked line ignored");
    gpio[5] = 1'b0;
    mask = '1;
    tick();

    // R9 battery fault
    batt_n = 1'b0;
    gpio[0] = 1'b1;
    stay_asleep(20, "R9 battery fault blocks wake");
    chk(!rst_n_o && cs_n, "R9 still in reset", int'(rst_n_o), 0);
    gpio[0] = 1'b0;
    tick();
    batt_n = 1'b1;
    tick();

    // R10 supply fault during reset release
    pde = 0; fw = 0;
    gpio[3] = 1'b1;
    edges_until(0, 1'b1, n);
    gpio[3] = 1'b0;
    repeat (3) tick();
    vdd_n = 1'b0;
    tick();
    chk(!reg_en && !rst_n_o, "R10 abort to sleep", int'(reg_en), 0);
    stay_asleep(10, "R10 stays asleep");
    vdd_n = 1'b1;

    // R11 supply never settles
    vdd_n = 1'b0;
    gpio[9] = 1'b1;
    edges_until(0, 1'b1, n);
    gpio[9] = 1'b0;
    hi = 1;
    for (int k = 0; k < T_VCC + 10; k++) begin
      tick();
      if (reg_en) hi++;
      if (rst_n_o) hi = 1000;
    end
    chk(hi == T_VCC, "R11 timeout width", hi, T_VCC);
    vdd_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule